// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block watches one external non-maskable interrupt pin and turns it into one interrupt request for a parent interrupt controller. The raw pin is brought into the clock domain through a two-flop synchroniser. A 2-bit trigger code then picks what counts as an event: a low level, a high level, a falling edge or a rising edge. Each event sets a sticky pending flag. The output request is raised while that flag is set and the source is unmasked.

Software reaches the block through a small register bus. The bus has an address, write data, a write strobe and combinational read data. There are three registers: a control word that holds the trigger code in its two lowest bits, a pending register that is cleared by writing one, and an enable register. A build parameter picks one of two placements for the enable register. In level modes the handler clears pending once it has finished its work. In edge modes it clears pending when it acknowledges the interrupt, before handling it.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the enable bit is 0, the pending flag is 0, the control word reads 0 (trigger code 0) and `irq_out` is 0.
- R2: The pin passes through two synchroniser flops that reset to 1. A level change on `nmi_pin` can set pending no earlier than the third rising clock edge after the change.
- R3: With trigger code 0, pending is set on every cycle in which the synchronised pin is 0.
- R4: With trigger code 2, pending is set on every cycle in which the synchronised pin is 1.
- R5: With trigger code 1, pending is set once for each 1-to-0 transition of the synchronised pin.
- R6: With trigger code 3, pending is set once for each 0-to-1 transition of the synchronised pin.
- R7: Pending is bit 0 at offset 0x04, and the other bits read 0. Writing 1 to bit 0 clears pending. Writing 0 to bit 0 leaves it unchanged.
- R8: In a level mode, if the pin is still active after a clear, pending is set again on the next cycle.
- R9: When a trigger event and a clearing write fall in the same cycle, pending stays set.
- R10: `irq_out` is 1 exactly when both pending and enable are 1. Pending still latches events while enable is 0.
- R11: Enable is bit 0 at offset 0x08 when `MAP_SEL` is 0 and at offset 0x34 when `MAP_SEL` is 1. The other of these two offsets is unmapped.
- R12: The control word at offset 0x00 stores every written bit and reads back the last value written. Only bits [1:0] select the trigger mode. Writes to other offsets leave the control word unchanged.
- R13: A read from any unmapped offset returns 0, and a write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Raw asynchronous interrupt pin |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The properties assume that `bus_we` is a clean single-cycle strobe and that `bus_addr` and `bus_wdata` are stable around the clock edge while it is high. The stimulus meets this by changing bus signals and the pin just after each rising edge, and by holding each write for exactly one cycle. The properties make no assumption about when the pin toggles relative to a mode change. The stimulus still lets the synchroniser settle after each mode write, so that every event can be attributed to the mode in force. The one exception is the deliberate collision between an event and a clear.

// File: rtl/nmi_line_pkg.sv
// Shared types and register offsets for the single-line NMI controller.
// Assumes byte offsets; the enable register placement depends on a map select.
package nmi_line_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'd0,
        TRIG_FALL     = 2'd1,
        TRIG_LVL_HIGH = 2'd2,
        TRIG_RISE     = 2'd3
    } trig_mode_e;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_PEND  = 'h04;
    localparam int OFF_EN_M0 = 'h08;
    localparam int OFF_EN_M1 = 'h34;

    // Enable register offset for a given register map.
    function automatic int en_offset(input int map_sel);
        return (map_sel == 0) ? OFF_EN_M0 : OFF_EN_M1;
    endfunction

endpackage

// File: rtl/nmi_pin_sync.sv
// Multi-flop synchroniser for the raw interrupt pin.
// Assumes the pin is asynchronous; every flop resets to RST_VAL (idle level).
module nmi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= din;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
// Trigger detector: turns the synchronised pin into a one-cycle or held
// event according to the 2-bit trigger code. Keeps the previous sample.
module nmi_trig_detect
    import nmi_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode,
    input  logic       lvl,
    output logic       evt
);

    logic prev;

    // Remember last cycle's synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    // Decode the selected trigger condition.
    always_comb begin
        unique case (mode)
            TRIG_LVL_LOW:  evt = !lvl;
            TRIG_FALL:     evt = prev && !lvl;
            TRIG_LVL_HIGH: evt = lvl;
            TRIG_RISE:     evt = !prev && lvl;
            default:       evt = 1'b0;
        endcase
    end

    // R5
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && evt) |=> !(mode == TRIG_FALL && evt));

    // R6
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_RISE && evt) |=> !(mode == TRIG_RISE && evt));

endmodule

// File: rtl/nmi_line_regs.sv
// Register file: control word, sticky pending flag with write-one-to-clear,
// and enable bit. Read data is combinational from the address.
module nmi_line_regs
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int MAP_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              evt,
    output trig_mode_e        mode,
    output logic              pend,
    output logic              en,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(en_offset(MAP_SEL));

    logic [DATA_W-1:0] ctrl;
    logic              hit_ctrl, hit_pend, hit_en, clr_req;

    assign hit_ctrl = (addr == A_CTRL);
    assign hit_pend = (addr == A_PEND);
    assign hit_en   = (addr == A_EN);
    assign clr_req  = we && hit_pend && wdata[0];
    assign mode     = trig_mode_e'(ctrl[1:0]);

    // Control word: stores the whole written value.
    always_ff @(posedge clk) begin
        if (!rst_n)               ctrl <= '0;
        else if (we && hit_ctrl)  ctrl <= wdata;
    end

    // Pending flag: an event sets it and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (evt)     pend <= 1'b1;
        else if (clr_req) pend <= 1'b0;
    end

    // Enable bit: unmasks the output when set.
    always_ff @(posedge clk) begin
        if (!rst_n)             en <= 1'b0;
        else if (we && hit_en)  en <= wdata[0];
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (hit_ctrl)      rdata = ctrl;
        else if (hit_pend) rdata[0] = pend;
        else if (hit_en)   rdata[0] = en;
    end

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !evt) |=> !pend);

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr_req) |=> $stable(pend));

    // R11
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_en) |=> $stable(en));

    // R12
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_ctrl) |=> $stable(ctrl));

endmodule

// File: rtl/nmi_line_ctrl.sv
// Top of the single-line NMI controller: synchroniser, trigger detector and
// register file. The request is pending AND enable. Assumes one source.
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MAP_SEL     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic       pin_s, evt, pend, en;
    trig_mode_e mode;

    nmi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(nmi_pin), .dout(pin_s)
    );

    nmi_trig_detect u_det (
        .clk(clk), .rst_n(rst_n), .mode(mode), .lvl(pin_s), .evt(evt)
    );

    nmi_line_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_SEL(MAP_SEL)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .evt(evt), .mode(mode), .pend(pend), .en(en),
        .rdata(bus_rdata)
    );

    // Request toward the parent controller.
    assign irq_out = pend && en;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

endmodule

// File: tb/nmi_line_ctrl_test.sv
module nmi_line_ctrl_test;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int MAP_SEL = 0;
    localparam logic [7:0] A_CTRL = 8'h00, A_PEND = 8'h04;
    localparam logic [7:0] A_EN  = (MAP_SEL == 0) ? 8'h08 : 8'h34;
    localparam logic [7:0] A_ALT = (MAP_SEL == 0) ? 8'h34 : 8'h08;

    logic clk = 0, rst_n = 0, nmi_pin = 1, bus_we = 0;
    logic [ADDR_W-1:0] bus_addr = A_PEND;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic irq_out;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit done = 0;

    // reference model state
    bit m_s1, m_s2, m_prev, m_pend, m_en;
    logic [DATA_W-1:0] m_ctrl;

    always #5 clk = ~clk;

    nmi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_SEL(MAP_SEL)) uut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // behavioural reference, stepped once per rising edge
    always @(posedge clk) begin
        bit ev, clr;
        int md;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_pend = 0; m_en = 0; m_ctrl = '0;
        end else begin
            md = int'(m_ctrl[1:0]);
            case (md)
                0: ev = !m_s2;
                1: ev = m_prev && !m_s2;
                2: ev = m_s2;
                default: ev = !m_prev && m_s2;
            endcase
            clr = bus_we && bus_addr == A_PEND && bus_wdata[0];
            if (ev) m_pend = 1; else if (clr) m_pend = 0;
            if (bus_we && bus_addr == A_EN) m_en = bus_wdata[0];
            if (bus_we && bus_addr == A_CTRL) m_ctrl = bus_wdata;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = nmi_pin;
        end
    end

    function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
        if (a == A_CTRL) return m_ctrl;
        if (a == A_PEND) return {31'b0, m_pend};
        if (a == A_EN)   return {31'b0, m_en};
        return '0;
    endfunction

    // compare outputs against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [DATA_W-1:0] e;
            checks++;
            if (irq_out !== (m_pend && m_en)) begin
                fails++;
                $display("FAIL %s irq_out got %0d exp %0d", phase, irq_out, m_pend && m_en);
            end
            e = exp_rd(bus_addr);
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s rdata@%0h got %0h exp %0h", phase, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0; bus_addr = A_PEND;
    endtask

    task automatic rd(input logic [7:0] a);
        @(posedge clk); #1;
        bus_addr = a;
        @(posedge clk); #1;
        bus_addr = A_PEND;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        summary();
    end

    initial begin
        cyc(3); rst_n = 1;
        // R1: reset state of every register and the request
        phase = "R1"; rd(A_CTRL); rd(A_PEND); rd(A_EN); cyc(2);
        // R12: control word stores all bits, mode still level-low
        phase = "R12"; wr(A_CTRL, 32'hABCD_0000); rd(A_CTRL); cyc(3);
        // R13: unmapped write and read
        phase = "R13"; wr(8'h10, 32'hFFFF_FFFF); rd(8'h10); rd(A_CTRL);
        // R11: alternate offset is unmapped, real one enables
        phase = "R11"; wr(A_ALT, 32'h1); rd(A_ALT); rd(A_EN);
        wr(A_EN, 32'h1); rd(A_EN);
        // R2 + R3: low level, observe latency
        phase = "R3"; nmi_pin = 0; cyc(6);
        // R7: writing zero keeps pending
        phase = "R7"; wr(A_PEND, 32'h0); nmi_pin = 1; cyc(4);
        wr(A_PEND, 32'h1); cyc(4);
        // R8: clear while still active re-sets next cycle
        phase = "R8"; nmi_pin = 0; cyc(5); wr(A_PEND, 32'h1); cyc(3);
        nmi_pin = 1; cyc(4); wr(A_PEND, 32'h1); cyc(3);
        // R4: active-high level
        phase = "R4"; nmi_pin = 0; cyc(4);
        wr(A_CTRL, 32'h0000_0002); cyc(4); wr(A_PEND, 32'h1); cyc(3);
        nmi_pin = 1; cyc(5); nmi_pin = 0; cyc(4); wr(A_PEND, 32'h1); cyc(3);
        // R6: rising edge, one set per transition
        phase = "R6"; wr(A_CTRL, 32'h5A00_0003); cyc(3); wr(A_PEND, 32'h1); cyc(3);
        nmi_pin = 1; cyc(6); wr(A_PEND, 32'h1); cyc(4);
        nmi_pin = 0; cyc(5);
        // R5: falling edge
        phase = "R5"; nmi_pin = 1; cyc(4); wr(A_CTRL, 32'h0000_0001); cyc(3);
        wr(A_PEND, 32'h1); cyc(3);
        nmi_pin = 0; cyc(6); wr(A_PEND, 32'h1); cyc(4);
        // R2: edge timing with pending cleared, pin rises then falls
        phase = "R2"; nmi_pin = 1; cyc(1); nmi_pin = 0; cyc(6);
        wr(A_PEND, 32'h1); cyc(2);
        // R9: event coincides with clear (rising mode)
        phase = "R9"; wr(A_CTRL, 32'h3); cyc(4); wr(A_PEND, 32'h1); cyc(2);
        nmi_pin = 1; @(posedge clk); @(posedge clk); #1;
        bus_addr = A_PEND; bus_wdata = 32'h1; bus_we = 1;
        @(posedge clk); #1; bus_we = 0; cyc(3);
        // R10: masked source still latches
        phase = "R10"; wr(A_EN, 32'h0); wr(A_PEND, 32'h1); cyc(2);
        nmi_pin = 0; cyc(3); nmi_pin = 1; cyc(5);
        rd(A_PEND); wr(A_EN, 32'h1); cyc(3); rd(A_EN);
        wr(A_EN, 32'h0); cyc(2);
        done = 1;
        summary();
    end

endmodule